// File: doc/BRIEF.md
# Two-Phase Serial Word Decoder

This block turns framed 20-bit serial words into parallel video or control data. An upstream framer delivers one word per parallel clock. It marks each word with a strobe and a phase flag that says whether the word belongs to the video phase or the blanking (control) phase. Video words yield an 18-bit pixel value and one spare status bit. Control words yield nine control bits. Five of those bits are sent three times each and are resolved by majority vote, so one corrupted copy of any of them is tolerated. The other four are sent once.

Both word kinds use bit 0 as a balance flag. When that flag is set, the transmitter inverted the rest of the word, and the block complements it back before use. A small state machine tracks the phase of the most recent word and drives the data-enable output from it. Each output bank is reloaded only by words of its own phase and keeps its last value otherwise.

The state machine has three states. ST_BLANK is the state after reset, before any word arrives. ST_VIDEO means the last word was a video word, and ST_CTRL means the last word was a control word. The transitions are named after their effect. T_TO_VIDEO is taken on a strobe with the video flag set. T_TO_CTRL is taken on a strobe with the flag clear. T_HOLD is taken when no strobe is present and keeps the current state. A strobe of either phase can be taken from any state.

Top module: `swd_top`

## Requirements
- R1: While reset is asserted, and after it until the first strobe, de_o is 0 and pix_o, ctl_o and spare_o are all zero.
- R2: A strobe with word_is_video=1 makes de_o 1 on the next clock. If word_in[0]=0, pix_o then equals word_in[19:2], with word_in[2] landing in pix_o[0].
- R3: For a video word with word_in[0]=1, pix_o on the next clock equals the bitwise complement of word_in[19:2].
- R4: spare_o takes word_in[1] of each video word on the next clock. It is never inverted, and it keeps its value while control words arrive.
- R5: A strobe with word_is_video=0 makes de_o 0 on the next clock. Unprotected control bits ctl_o[8:5] come from word_in[19:16] with no voting.
- R6: Voted control bit ctl_o[k], for k from 0 to 4, is 1 when at least two of word_in[3k+1], word_in[3k+2] and word_in[3k+3] are 1.
- R7: For a control word with word_in[0]=1, word_in[19:1] is complemented before the voting of R6 and the selection of R5.
- R8: pix_o and spare_o hold their values across control words, and ctl_o holds its value across video words.
- R9: In a cycle without a strobe, de_o, pix_o, ctl_o and spare_o all keep their values, whatever word_in and word_is_video carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_vld | input | 1 | Strobe: word_in carries a framed word this cycle |
| word_is_video | input | 1 | Phase flag of the word: 1 for video, 0 for control |
| word_in | input | 20 | Framed serial word, bit 0 received first |
| de_o | output | 1 | Data enable: 1 after a video word, 0 after a control word |
| pix_o | output | 18 | Decoded pixel data |
| ctl_o | output | 9 | Decoded control data |
| spare_o | output | 1 | Spare status bit from the last video word |

## Verification
The properties assume that word_is_video is meaningful only when word_vld is high. They also assume that the framer has already aligned word_in, so bit 0 is always the balance flag. The stimulus meets both assumptions by changing word_in and the phase flag only on the falling clock edge. It raises the strobe only for complete words and, during idle cycles, drives arbitrary values on the unqualified lines so the hold behaviour is exercised. Control words are built with at most one disagreeing copy per voted bit, except where a deliberate two-copy pattern checks that the majority wins.

// File: rtl/swd_pkg.sv
`timescale 1ns/1ps
package swd_pkg;

    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_VIDEO = 2'd1,
        ST_CTRL  = 2'd2
    } swd_phase_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/swd_vid_dec.sv
`timescale 1ns/1ps
module swd_vid_dec #(
    parameter int PIX_W = 18
) (
    input  logic [PIX_W+1:0] word_in,
    output logic [PIX_W-1:0] pix,
    output logic             spare
);
    localparam int SYM_LO = 2;

    logic flip;

    always_comb begin
        flip  = word_in[0];
        spare = word_in[1];
        pix   = word_in[PIX_W+SYM_LO-1:SYM_LO] ^ {PIX_W{flip}};
    end
endmodule

// File: rtl/swd_ctl_vote.sv
`timescale 1ns/1ps
module swd_ctl_vote
    import swd_pkg::*;
#(
    parameter int VOTED_N = 5,
    parameter int REP     = 3,
    parameter int PLAIN_N = 4
) (
    input  logic [VOTED_N*REP+PLAIN_N:0] word_in,
    output logic [VOTED_N+PLAIN_N-1:0]   ctl
);
    localparam int BODY_W     = VOTED_N*REP + PLAIN_N;
    localparam int PLAIN_BASE = VOTED_N*REP;

    logic [BODY_W-1:0] body;

    // bit 0 is the balance flag; undo inversion of the rest before voting
    assign body = word_in[BODY_W:1] ^ {BODY_W{word_in[0]}};

    for (genvar k = 0; k < VOTED_N; k++) begin : g_vote
        assign ctl[k] = maj3(body[k*REP], body[k*REP+1], body[k*REP+2]);
    end

    for (genvar p = 0; p < PLAIN_N; p++) begin : g_plain
        assign ctl[VOTED_N+p] = body[PLAIN_BASE+p];
    end
endmodule

// File: rtl/swd_top.sv
`timescale 1ns/1ps
module swd_top
    import swd_pkg::*;
#(
    parameter int PIX_W   = 18,
    parameter int VOTED_N = 5,
    parameter int REP     = 3,
    parameter int PLAIN_N = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       word_vld,
    input  logic                       word_is_video,
    input  logic [PIX_W+1:0]           word_in,
    output logic                       de_o,
    output logic [PIX_W-1:0]           pix_o,
    output logic [VOTED_N+PLAIN_N-1:0] ctl_o,
    output logic                       spare_o
);
    localparam int CTL_W  = VOTED_N + PLAIN_N;
    localparam int WORD_W = PIX_W + 2;

    swd_phase_e state_q, state_d;

    logic [PIX_W-1:0] vid_pix;
    logic             vid_spare;
    logic [CTL_W-1:0] ctl_dec;
    logic             take_vid, take_ctl;

    swd_vid_dec #(.PIX_W(PIX_W)) vid_i (
        .word_in (word_in),
        .pix     (vid_pix),
        .spare   (vid_spare)
    );

    swd_ctl_vote #(.VOTED_N(VOTED_N), .REP(REP), .PLAIN_N(PLAIN_N)) vote_i (
        .word_in (word_in[VOTED_N*REP+PLAIN_N:0]),
        .ctl     (ctl_dec)
    );

    assign take_vid = word_vld &  word_is_video;
    assign take_ctl = word_vld & ~word_is_video;

    // next-state: T_TO_VIDEO, T_TO_CTRL, T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK, ST_VIDEO, ST_CTRL: begin
                if (take_vid)      state_d = ST_VIDEO;
                else if (take_ctl) state_d = ST_CTRL;
                else               state_d = state_q;
            end
            default: state_d = ST_BLANK;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BLANK;
        else        state_q <= state_d;
    end

    // output banks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_o   <= '0;
            spare_o <= 1'b0;
            ctl_o   <= '0;
        end else begin
            if (take_vid) begin
                pix_o   <= vid_pix;
                spare_o <= vid_spare;
            end
            if (take_ctl) begin
                ctl_o <= ctl_dec;
            end
        end
    end

    assign de_o = (state_q == ST_VIDEO);

    logic unused_ok;
    assign unused_ok = ^{word_in[WORD_W-1:0]} & 1'b0;
endmodule

// File: rtl/swd_chk.sv
`timescale 1ns/1ps
module swd_chk #(
    parameter int PIX_W   = 18,
    parameter int VOTED_N = 5,
    parameter int REP     = 3,
    parameter int PLAIN_N = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       word_vld,
    input logic                       word_is_video,
    input logic [PIX_W+1:0]           word_in,
    input logic                       de_o,
    input logic [PIX_W-1:0]           pix_o,
    input logic [VOTED_N+PLAIN_N-1:0] ctl_o,
    input logic                       spare_o
);
    localparam int CTL_W      = VOTED_N + PLAIN_N;
    localparam int PLAIN_BASE = 1 + VOTED_N*REP;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!de_o && pix_o == '0 && ctl_o == '0 && !spare_o)); // R1

    AST_DE_AFTER_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && word_is_video) |=> de_o); // R2

    AST_DE_AFTER_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && !word_is_video) |=> !de_o); // R5

    AST_PLAIN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && !word_is_video) |=>
        ctl_o[CTL_W-1:VOTED_N] ==
            ($past(word_in[PIX_W+1:PLAIN_BASE]) ^ {PLAIN_N{$past(word_in[0])}})); // R7

    AST_SPARE_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && word_is_video) |=> spare_o == $past(word_in[1])); // R4

    AST_PIX_HOLD_IN_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && !word_is_video) |=> ($stable(pix_o) && $stable(spare_o))); // R8

    AST_CTL_HOLD_IN_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && word_is_video) |=> $stable(ctl_o)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> ($stable(de_o) && $stable(pix_o) && $stable(ctl_o) && $stable(spare_o))); // R9
endmodule

bind swd_top swd_chk #(
    .PIX_W(PIX_W), .VOTED_N(VOTED_N), .REP(REP), .PLAIN_N(PLAIN_N)
) chk_i (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_is_video(word_is_video),
    .word_in(word_in), .de_o(de_o), .pix_o(pix_o), .ctl_o(ctl_o), .spare_o(spare_o)
);

// File: tb/swd_top_tb_top.sv
`timescale 1ns/1ps
module swd_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_vld = 1'b0;
    logic        word_is_video = 1'b0;
    logic [19:0] word_in = '0;
    logic        de_o;
    logic [17:0] pix_o;
    logic [8:0]  ctl_o;
    logic        spare_o;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    swd_top dut_i (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_is_video(word_is_video),
        .word_in(word_in), .de_o(de_o), .pix_o(pix_o), .ctl_o(ctl_o), .spare_o(spare_o)
    );

    // {is_video, word[19:0], expected[17:0] (ctl zero-extended), expected spare}
    localparam int NV = 10;
    localparam logic [39:0] VEC [NV] = '{
        {1'b1, 20'h00004, 18'h00001, 1'b0},   // R2 single symbol bit
        {1'b1, 20'hFFFFC, 18'h3FFFF, 1'b0},   // R2 all symbols
        {1'b1, 20'h00007, 18'h3FFFE, 1'b1},   // R3 inverted, R4 spare set
        {1'b1, 20'hA5A58, 18'h29696, 1'b0},   // R2 mixed pattern
        {1'b0, 20'h0000E, 18'h00001, 1'b0},   // R6 all copies set
        {1'b0, 20'h00032, 18'h00002, 1'b0},   // R6 two-of-three and one-of-three
        {1'b0, 20'hF4000, 18'h001E0, 1'b0},   // R5 plain bits
        {1'b0, 20'h00001, 18'h001FF, 1'b0},   // R7 inverted zero body
        {1'b0, 20'h1000F, 18'h001DE, 1'b0},   // R7 inverted pattern
        {1'b0, 20'h00A80, 18'h00004, 1'b0}    // R6 single bad copy rejected
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic vid, input logic [19:0] w);
        @(negedge clk);
        word_vld = 1'b1; word_is_video = vid; word_in = w;
        @(negedge clk);
        word_vld = 1'b0; word_in = ~w; word_is_video = ~vid;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [17:0] last_pix;
        logic [8:0]  last_ctl;
        logic        last_spare;
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 de in reset", 32'(de_o), 0);
        check("R1 pix in reset", 32'(pix_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ctl after reset", 32'(ctl_o), 0);
        check("R1 spare after reset", 32'(spare_o), 0);
        last_pix = '0; last_ctl = '0; last_spare = 1'b0;

        for (int i = 0; i < NV; i++) begin
            send(VEC[i][39], VEC[i][38:19]);
            if (VEC[i][39]) begin
                check("R2/R3 pix", 32'(pix_o), 32'(VEC[i][18:1]));
                check("R2 de high", 32'(de_o), 1);
                check("R4 spare", 32'(spare_o), 32'(VEC[i][0]));
                check("R8 ctl held", 32'(ctl_o), 32'(last_ctl));
                last_pix = VEC[i][18:1]; last_spare = VEC[i][0];
            end else begin
                check("R5/R6/R7 ctl", 32'(ctl_o), 32'(VEC[i][9:1]));
                check("R5 de low", 32'(de_o), 0);
                check("R8 pix held", 32'(pix_o), 32'(last_pix));
                check("R4 spare held", 32'(spare_o), 32'(last_spare));
                last_ctl = VEC[i][9:1];
            end
        end

        // R9 idle cycles with noise on unqualified lines
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            word_in = 20'h5A5A5 ^ 20'(k * 7919); word_is_video = k[0];
            check("R9 de idle", 32'(de_o), 0);
            check("R9 pix idle", 32'(pix_o), 32'(last_pix));
            check("R9 ctl idle", 32'(ctl_o), 32'(last_ctl));
        end

        // back-to-back strobes: video then control
        @(negedge clk);
        word_vld = 1'b1; word_is_video = 1'b1; word_in = 20'h00008;
        @(negedge clk);
        check("R2 b2b pix", 32'(pix_o), 32'h2);
        check("R2 b2b de", 32'(de_o), 1);
        word_is_video = 1'b0; word_in = 20'h70000;
        @(negedge clk);
        word_vld = 1'b0;
        check("R5 b2b ctl", 32'(ctl_o), 32'h0E0);
        check("R8 b2b pix held", 32'(pix_o), 32'h2);
        check("R5 b2b de", 32'(de_o), 0);

        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset pix", 32'(pix_o), 0);
        check("R1 re-reset ctl", 32'(ctl_o), 0);
        check("R1 re-reset de", 32'(de_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule